// File: doc/BRIEF.md
# Multiframe Timing Generator with Reference-Pulse Alignment

This block lives in the link clock domain of a subclass 1 serial converter receiver. Each link clock carries four octets, so one local multiframe of K frames of F octets lasts F·K/4 link clocks. The block keeps a multiframe counter with that period and emits a one-cycle boundary strobe. The receive buffer uses that strobe to release data at a fixed point. The block also generates a periodic reference pulse, one multiframe apart, which the system sends both to the converter and back into this block's reference input.

A rising edge on the reference input restarts the multiframe counter. The restart happens on every edge in continuous mode. In single mode only the first edge after arming counts. Status bits show whether an edge has arrived and whether the block is still armed. A two-word register port holds the framing values and the mode controls. It rejects a framing setting whose multiframe would not be a whole number of link clocks.

Top module: `lmfc_sysref_gen`

## Requirements
- R1: After reset, word 0 reads 16'h2002 (bits [7:0] octets per frame F = 2, bits [15:8] frames per multiframe K = 32). Word 1 reads 16'h0004. The reference output is low.
- R2: Word 1 bit 1 enables the generator. While it is set, `sysref_out` is high for exactly one cycle every F·K/4 cycles. The first pulse comes in the cycle the enabling write takes effect.
- R3: While word 1 bit 1 is clear, `sysref_out` stays low.
- R4: A write to word 0 with F·K zero or not a multiple of 4 leaves F and K unchanged and sets word 1 bit 3. An accepted write to word 0 clears bit 3.
- R5: With no reference edge, `lmfc_tick` pulses every F·K/4 cycles.
- R6: An accepted rising edge on `sysref_in` makes `lmfc_tick` high in the next cycle, with `lmfc_count` at zero. Ticks then follow every F·K/4 cycles.
- R7: In single mode (word 1 bit 0 = 0) with the armed flag clear, a rising edge leaves the tick phase unchanged.
- R8: Word 1 bit 2 is the armed flag. It is 1 after reset and clears when the first edge is taken. Writing 1 to bit 2 sets it again, so the next edge realigns.
- R9: In continuous mode (word 1 bit 0 = 1), every rising edge realigns the counter.
- R10: Word 1 bit 4 becomes 1 on any rising edge of `sysref_in`. Writing 1 to bit 4 clears it.
- R11: A reference input held high realigns the counter only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 framing, 1 control/status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| sysref_in | input | 1 | Reference pulse input |
| sysref_out | output | 1 | Generated reference pulse |
| lmfc_tick | output | 1 | Multiframe boundary strobe |
| lmfc_count | output | 14 | Current position in the multiframe |

## Verification
A wrong multiframe count shows up at `lmfc_tick` within one period. The monitor compares every cycle of a window against the tick cycles it expects, so a tick that is late, early or extra is caught in the cycle it happens. A wrong armed or mode state shows up at the first off-phase reference edge after it: the tick either moves when it should hold its phase, or holds when it should move. The register reads expose these flags directly.

// File: rtl/lmfc_sysref_gen.sv
module lmfc_sysref_gen #(
  parameter int OCT_W = 8,
  parameter int KF_W  = 8,
  parameter int F_RST = 2,
  parameter int K_RST = 32,
  localparam int DW    = OCT_W + KF_W,
  localparam int CNT_W = DW - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             sysref_in,
  output logic             sysref_out,
  output logic             lmfc_tick,
  output logic [CNT_W-1:0] lmfc_count
);

  logic [OCT_W-1:0] f_q;
  logic [KF_W-1:0]  k_q;
  logic             cont_q, gen_en_q, armed_q, err_q, seen_q, sref_q;
  logic [CNT_W-1:0] lmfc_q, gen_q;

  wire [DW-1:0]    fk_cur  = DW'(f_q) * DW'(k_q);
  wire [DW-1:0]    fk_new  = DW'(reg_wdata[OCT_W-1:0]) * DW'(reg_wdata[DW-1:OCT_W]);
  wire             cfg_ok  = (fk_new[1:0] == 2'b00) && (fk_new != '0);
  wire [CNT_W-1:0] last    = fk_cur[DW-1:2] - CNT_W'(1);
  wire             rise    = sysref_in & ~sref_q;
  wire             take    = rise & (cont_q | armed_q);
  wire             cfg_wr  = reg_wr & ~reg_addr;
  wire             ctl_wr  = reg_wr & reg_addr;
  wire             unused_ok = &{1'b0, reg_wdata[DW-1:5]};

  assign sysref_out = gen_en_q && (gen_q == '0);
  assign lmfc_tick  = (lmfc_q == '0);
  assign lmfc_count = lmfc_q;
  assign reg_rdata  = reg_addr ? {{(DW-5){1'b0}}, seen_q, err_q, armed_q, gen_en_q, cont_q}
                               : {k_q, f_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q      <= OCT_W'(F_RST);
      k_q      <= KF_W'(K_RST);
      cont_q   <= 1'b0;
      gen_en_q <= 1'b0;
      armed_q  <= 1'b1;
      err_q    <= 1'b0;
      seen_q   <= 1'b0;
      sref_q   <= 1'b0;
      lmfc_q   <= '0;
      gen_q    <= '0;
    end else begin
      sref_q <= sysref_in;

      if (take || lmfc_q >= last) lmfc_q <= '0;
      else                        lmfc_q <= lmfc_q + CNT_W'(1);

      if (!gen_en_q || gen_q >= last) gen_q <= '0;
      else                            gen_q <= gen_q + CNT_W'(1);

      if (rise) seen_q  <= 1'b1;
      if (take) armed_q <= 1'b0;

      if (cfg_wr) begin
        err_q <= !cfg_ok;
        if (cfg_ok) begin
          f_q <= reg_wdata[OCT_W-1:0];
          k_q <= reg_wdata[DW-1:OCT_W];
        end
      end
      if (ctl_wr) begin
        cont_q   <= reg_wdata[0];
        gen_en_q <= reg_wdata[1];
        if (reg_wdata[2]) armed_q <= 1'b1;
        if (reg_wdata[4]) seen_q  <= 1'b0;
      end
    end
  end

  a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sysref_out && last != '0) |=> !sysref_out);

  a_r6_edge_realigns: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sysref_in) && (cont_q || armed_q)) |=> (lmfc_tick && lmfc_count == '0));

  a_r8_rearm_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(reg_wr && reg_addr && reg_wdata[2]));

  a_r4_bad_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ok) |=> ($stable(f_q) && $stable(k_q) && err_q));

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |-> !sysref_out);

endmodule

// File: tb/test_lmfc_sysref_gen.sv
`timescale 1ns/1ps
module test_lmfc_sysref_gen;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_addr = 0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        sysref_drv = 0, sysref_out, lmfc_tick;
  logic [13:0] lmfc_count;

  int checks = 0, errors = 0, cyc = 0, cur_p = 16, mon_from = 0;
  int q[$];
  string cur_tag = "R6";

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lmfc_sysref_gen i_lmfc_sysref_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sysref_in(sysref_drv),
    .sysref_out(sysref_out), .lmfc_tick(lmfc_tick), .lmfc_count(lmfc_count));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(bit a, output int d);
    @(negedge clk); reg_addr = a; #1; d = int'(reg_rdata);
  endtask

  // Monitor: every cycle in the window must match the expected tick list.
  always @(negedge clk) begin
    if (q.size() > 0 && cyc >= mon_from) begin
      automatic bit exp = (cyc == q[0]);
      if (lmfc_tick !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d tick actual=%0b expected=%0b", cur_tag, cyc, lmfc_tick, exp);
      end
      if (exp) begin
        checks++;
        void'(q.pop_front());
      end
    end
  end

  // Driver: raise the reference (optionally at a set phase), push expected ticks.
  task automatic pulse(string tag, int hold, int n, bit follow, int orig,
                       bit align, int aorig, int aofs, output int e);
    int t;
    @(negedge clk);
    while (align && (((cyc + 1 - aorig) % cur_p + cur_p) % cur_p) != aofs) @(negedge clk);
    sysref_drv = 1;
    e = cyc;
    cur_tag = tag;
    mon_from = e + 1;
    t = follow ? e + 1 : orig;
    while (t <= e) t += cur_p;
    for (int k = 0; k < n; k++) q.push_back(t + k * cur_p);
    repeat (hold) @(negedge clk);
    sysref_drv = 0;
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic tick_spacing(string tag);
    int t1;
    repeat (2 * cur_p) @(negedge clk);
    while (!lmfc_tick) @(negedge clk);
    t1 = cyc;
    @(negedge clk);
    while (!lmfc_tick) @(negedge clk);
    check(tag, cyc - t1, cur_p);
  endtask

  task automatic gen_window(string tag, int len, bit on);
    int w, bad;
    w = cyc; bad = 0;
    #1;
    for (int i = 0; i < len; i++) begin
      if (i > 0) begin @(negedge clk); #1; end
      if (sysref_out !== (on && ((cyc - w) % cur_p == 0))) bad++;
    end
    check(tag, bad, 0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int d, e1, e2, e3;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, d); check("R1 cfg", d, 16'h2002);
    rd(1, d); check("R1 ctrl", d, 16'h0004);
    check("R1 sysref_out", int'(sysref_out), 0);
    // R4 rejection
    wr(0, 16'h1503);
    rd(0, d); check("R4 cfg kept", d, 16'h2002);
    rd(1, d); check("R4 err set", d, 16'h000C);
    wr(0, 16'h2000);
    rd(0, d); check("R4 zero F kept", d, 16'h2002);
    wr(0, 16'h2003); cur_p = 24;
    rd(0, d); check("R4 accepted", d, 16'h2003);
    rd(1, d); check("R4 err cleared", d, 16'h0004);
    // R5 free-running period
    tick_spacing("R5 P24");
    wr(0, 16'h2002); cur_p = 16;
    tick_spacing("R5 P16");
    // R6 first edge in single mode
    pulse("R6", 2, 3, 1, 0, 0, 0, 0, e1);
    rd(1, d); check("R8 R10 disarmed seen", d, 16'h0010);
    // R7 later edge ignored in single mode
    pulse("R7", 2, 3, 0, e1 + 1, 1, e1 + 1, 5, e2);
    // R10 clear seen
    wr(1, 16'h0010);
    rd(1, d); check("R10 seen cleared", d, 16'h0000);
    // R8 re-arm
    wr(1, 16'h0004);
    rd(1, d); check("R8 armed", d, 16'h0004);
    pulse("R8", 2, 2, 1, 0, 1, e1 + 1, 7, e2);
    // R9 continuous mode
    wr(1, 16'h0001);
    pulse("R9 first", 2, 2, 1, 0, 1, e2 + 1, 3, e3);
    pulse("R9 second", 2, 2, 1, 0, 1, e3 + 1, 9, e3);
    // R11 level held high
    pulse("R11", 3 * 16, 4, 1, 0, 1, e3 + 1, 6, e3);
    // R2 / R3 generator
    wr(1, 16'h0002);
    gen_window("R2 P16", 3 * cur_p, 1);
    wr(1, 16'h0000);
    gen_window("R3 off", 40, 0);
    wr(0, 16'h1001); cur_p = 4;
    wr(1, 16'h0002);
    gen_window("R2 P4", 20, 1);
    tick_spacing("R5 P4");
    summary();
  end
endmodule